// File: doc/BRIEF.md
# Prescaled Pulse Width Modulator

This block generates one or two pulse width modulated outputs from a single input clock. Each channel is programmed through three registers behind a small memory-mapped port. Those registers set a 6-bit clock prescale, a 10-bit period length, a duty length, a full-duty override and the way the channel stops. A level-sensitive run input per channel starts and stops the waveform.

While a channel runs, a prescaler counts input clocks and a period counter counts prescaled ticks. The output is active from the start of each period until the duty count has elapsed. Period, duty and prescale values are copied into working registers only when a channel starts or when a period ends. Software can therefore change them at any time without producing a short or stretched pulse. When the run input falls, the channel either stops on the next clock or finishes its current period first. A control bit chooses between the two.

The register port has no back-pressure. A write is taken on the clock edge where `bus_wr` is high. Read data follows `bus_addr` combinationally in the same cycle. Bits [3:0] of the address select the register and the bits above them select the channel. Each channel occupies a 16-byte window.

Top module: `pulse_mod_unit`

## Requirements
- R1: Within a channel window, the control register sits at offset 0x00, with prescale in bits [5:0] and the abrupt-stop select in bit 6. The duty register sits at offset 0x04, with the duty count in bits [9:0] and the full-duty override in bit 10. The period register sits at offset 0x08, with the period count in bits [9:0]. Every register reads back its written value with all unused bits as zero, and offset 0x0C reads as zero.
- R2: After reset, all registers read zero and every output is low.
- R3: Once running, a channel repeats a period of (prescale+1)*(period+1) clocks. The output is high for the first (prescale+1)*duty clocks of each period. This holds for every prescale value from 0 to 63.
- R4: A duty count of zero without the override keeps the output low for the whole period.
- R5: With the full-duty bit set, the output is high for the whole period whatever the duty count holds.
- R6: A duty count greater than period+1 gives an output that is high for the whole period.
- R7: With bit 6 clear, dropping the run input lets the current period finish, and the output is low from the next period boundary on.
- R8: With bit 6 set, dropping the run input ends the waveform on the next clock edge, and the output is low from then on.
- R9: Values written while a channel runs take effect at the first period boundary after the write.
- R10: The second channel uses the same layout at base 0x10. It runs from its own run input and does not disturb the first channel.
- R11: An idle channel drives its output low. The first period begins on the clock edge where the run input is first seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address: channel in [4], register in [3:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| run_en | input | 2 | Per-channel run request |
| pwm_out | output | 2 | Per-channel modulated output, registered |

## Verification
The assertions assume that `run_en` and the bus inputs are synchronous to `clk` and stable around its rising edge. They also assume that register contents change only through the write port. The stimulus changes every input on the falling edge and holds it for at least a full cycle. Prescale and period values stay small enough that several whole periods, and the stop behaviour at a chosen point inside a period, can be checked cycle by cycle against a waveform computed from the requirements.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int OFS_W      = 4;
  localparam int OFS_CTRL   = 0;
  localparam int OFS_DUTY   = 4;
  localparam int OFS_PERIOD = 8;

  typedef enum logic [1:0] {
    SEL_CTRL,
    SEL_DUTY,
    SEL_PERIOD,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    case (ofs)
      OFS_W'(OFS_CTRL):   decode_ofs = SEL_CTRL;
      OFS_W'(OFS_DUTY):   decode_ofs = SEL_DUTY;
      OFS_W'(OFS_PERIOD): decode_ofs = SEL_PERIOD;
      default:            decode_ofs = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pmu_regs.sv
module pmu_regs
  import pmu_pkg::*;
#(
  parameter int PRE_W  = 6,
  parameter int PER_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [PRE_W-1:0]  cfg_pre,
  output logic              cfg_abrupt,
  output logic [PER_W-1:0]  cfg_dc,
  output logic              cfg_full,
  output logic [PER_W-1:0]  cfg_pv
);

  localparam int CTRL_W = PRE_W + 1;
  localparam int DUTY_W = PER_W + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DUTY_W-1:0] duty_q;
  logic [PER_W-1:0]  per_q;
  reg_sel_e          sel;

  assign sel = decode_ofs(ofs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      duty_q <= '0;
      per_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CTRL:   ctrl_q <= wr_data[CTRL_W-1:0];
        SEL_DUTY:   duty_q <= wr_data[DUTY_W-1:0];
        SEL_PERIOD: per_q  <= wr_data[PER_W-1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (sel)
      SEL_CTRL:   rd_data[CTRL_W-1:0] = ctrl_q;
      SEL_DUTY:   rd_data[DUTY_W-1:0] = duty_q;
      SEL_PERIOD: rd_data[PER_W-1:0]  = per_q;
      default:    ;
    endcase
  end

  assign cfg_pre    = ctrl_q[PRE_W-1:0];
  assign cfg_abrupt = ctrl_q[PRE_W];
  assign cfg_dc     = duty_q[PER_W-1:0];
  assign cfg_full   = duty_q[PER_W];
  assign cfg_pv     = per_q;

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:DUTY_W] == '0); // R1

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_PERIOD) |=> (cfg_pv == $past(wr_data[PER_W-1:0]))); // R1

endmodule

// File: rtl/pmu_engine.sv
module pmu_engine #(
  parameter int PRE_W = 6,
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [PRE_W-1:0] cfg_pre,
  input  logic             cfg_abrupt,
  input  logic [PER_W-1:0] cfg_dc,
  input  logic             cfg_full,
  input  logic [PER_W-1:0] cfg_pv,
  output logic             pwm_q
);

  logic             running_q, n_running;
  logic [PRE_W-1:0] pre_cnt_q, n_pre_cnt;
  logic [PER_W-1:0] per_cnt_q, n_per_cnt;
  logic [PRE_W-1:0] sh_pre_q, n_sh_pre;
  logic [PER_W-1:0] sh_pv_q, n_sh_pv;
  logic [PER_W-1:0] sh_dc_q, n_sh_dc;
  logic             sh_full_q, n_sh_full;
  logic             n_pwm;
  logic             pre_end, per_end, boundary;

  assign pre_end  = (pre_cnt_q == sh_pre_q);
  assign per_end  = (per_cnt_q == sh_pv_q);
  assign boundary = running_q && pre_end && per_end;

  always_comb begin
    n_running = running_q;
    n_pre_cnt = pre_cnt_q;
    n_per_cnt = per_cnt_q;
    n_sh_pre  = sh_pre_q;
    n_sh_pv   = sh_pv_q;
    n_sh_dc   = sh_dc_q;
    n_sh_full = sh_full_q;
    if (!running_q) begin
      if (run_en) begin
        n_running = 1'b1;
        n_pre_cnt = '0;
        n_per_cnt = '0;
        n_sh_pre  = cfg_pre;
        n_sh_pv   = cfg_pv;
        n_sh_dc   = cfg_dc;
        n_sh_full = cfg_full;
      end
    end else if (!run_en && cfg_abrupt) begin
      n_running = 1'b0;
      n_pre_cnt = '0;
      n_per_cnt = '0;
    end else if (pre_end) begin
      n_pre_cnt = '0;
      if (per_end) begin
        n_per_cnt = '0;
        if (run_en) begin
          n_sh_pre  = cfg_pre;
          n_sh_pv   = cfg_pv;
          n_sh_dc   = cfg_dc;
          n_sh_full = cfg_full;
        end else begin
          n_running = 1'b0;
        end
      end else begin
        n_per_cnt = per_cnt_q + 1'b1;
      end
    end else begin
      n_pre_cnt = pre_cnt_q + 1'b1;
    end
    n_pwm = n_running && (n_sh_full || (n_per_cnt < n_sh_dc));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      pre_cnt_q <= '0;
      per_cnt_q <= '0;
      sh_pre_q  <= '0;
      sh_pv_q   <= '0;
      sh_dc_q   <= '0;
      sh_full_q <= 1'b0;
      pwm_q     <= 1'b0;
    end else begin
      running_q <= n_running;
      pre_cnt_q <= n_pre_cnt;
      per_cnt_q <= n_per_cnt;
      sh_pre_q  <= n_sh_pre;
      sh_pv_q   <= n_sh_pv;
      sh_dc_q   <= n_sh_dc;
      sh_full_q <= n_sh_full;
      pwm_q     <= n_pwm;
    end
  end

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |-> (pre_cnt_q <= sh_pre_q)); // R3

  AST_PER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |-> (per_cnt_q <= sh_pv_q)); // R3

  AST_ABRUPT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !run_en && cfg_abrupt) |=> !pwm_q); // R8

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !boundary) |=> ($stable(sh_pv_q) && $stable(sh_dc_q))); // R9

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !sh_full_q && sh_dc_q == '0) |-> !pwm_q); // R4

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> !pwm_q); // R11

  AST_GRACEFUL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !run_en && !cfg_abrupt && !boundary) |=> running_q); // R7

endmodule

// File: rtl/pulse_mod_unit.sv
module pulse_mod_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int PRE_W  = 6,
  parameter int PER_W  = 10,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] run_en,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int CH_W = ADDR_W - OFS_W;

  logic [CH_W-1:0]   ch_idx;
  logic [OFS_W-1:0]  reg_ofs;
  logic [DATA_W-1:0] ch_rd [NUM_CH];

  assign ch_idx  = bus_addr[ADDR_W-1:OFS_W];
  assign reg_ofs = bus_addr[OFS_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PRE_W-1:0] pre;
    logic             abrupt;
    logic [PER_W-1:0] dc;
    logic             full;
    logic [PER_W-1:0] pv;
    logic             sel_me;

    assign sel_me = (ch_idx == CH_W'(c));

    pmu_regs #(.PRE_W(PRE_W), .PER_W(PER_W), .DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bus_wr && sel_me),
      .ofs        (reg_ofs),
      .wr_data    (bus_wdata),
      .rd_data    (ch_rd[c]),
      .cfg_pre    (pre),
      .cfg_abrupt (abrupt),
      .cfg_dc     (dc),
      .cfg_full   (full),
      .cfg_pv     (pv)
    );

    pmu_engine #(.PRE_W(PRE_W), .PER_W(PER_W)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (run_en[c]),
      .cfg_pre    (pre),
      .cfg_abrupt (abrupt),
      .cfg_dc     (dc),
      .cfg_full   (full),
      .cfg_pv     (pv),
      .pwm_q      (pwm_out[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_idx == CH_W'(c)) bus_rdata = ch_rd[c];
    end
  end

  AST_OUT_LOW_IN_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwm_out == '0)); // R2

endmodule

// File: tb/pulse_mod_unit_test.sv
module pulse_mod_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  run_en = '0;
  logic [1:0]  pwm_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [1:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  pulse_mod_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .run_en    (run_en),
    .pwm_out   (pwm_out)
  );

  function automatic bit wave(int pre, int pv, int dc, bit full, int j);
    int len = (pre + 1) * (pv + 1);
    int hi  = full ? len : (pre + 1) * dc;
    return (j % len) < hi;
  endfunction

  task automatic push(int ch, bit v, string tag);
    logic [1:0] e = '0;
    e[ch] = v;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if (pwm_out !== e) begin
          n_fail++;
          $display("FAIL %s pwm_out actual=%b expected=%b", t, pwm_out, e);
        end
      end
    end
  end

  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_check(logic [4:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    n_tests++;
    if (bus_rdata !== e) begin
      n_fail++;
      $display("FAIL %s read 0x%0h actual=0x%0h expected=0x%0h", tag, a, bus_rdata, e);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Program a channel, run it, drop run after m cycles, expect stop point
  task automatic run_case(int ch, int pre, int pv, int dc, bit full, bit abrupt,
                          int m, string tag);
    int len = (pre + 1) * (pv + 1);
    int stop_at;
    logic [4:0] base = (ch == 1) ? 5'h10 : 5'h00;
    bus_write(base + 5'h0, 32'((abrupt ? 64 : 0) + pre));
    bus_write(base + 5'h4, 32'((full ? 1024 : 0) + dc));
    bus_write(base + 5'h8, 32'(pv));
    stop_at = abrupt ? m : ((m + len - 1) / len) * len;
    run_en[ch] = 1'b1;
    for (int j = 0; j < stop_at; j++) push(ch, wave(pre, pv, dc, full, j), tag);
    for (int j = 0; j < 6; j++) push(ch, 1'b0, tag);
    repeat (m) @(negedge clk);
    run_en[ch] = 1'b0;
    drain();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    n_tests++;
    if (pwm_out !== 2'b00) begin
      n_fail++;
      $display("FAIL R2 pwm_out actual=%b expected=00", pwm_out);
    end
    read_check(5'h00, 0, "R2");
    read_check(5'h04, 0, "R2");
    read_check(5'h08, 0, "R2");
    read_check(5'h18, 0, "R2");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: readback masks unused bits
    bus_write(5'h00, 32'hFFFF_FFFF);
    bus_write(5'h04, 32'hFFFF_FFFF);
    bus_write(5'h08, 32'hFFFF_FFFF);
    bus_write(5'h0C, 32'hFFFF_FFFF);
    read_check(5'h00, 32'h7F, "R1");
    read_check(5'h04, 32'h7FF, "R1");
    read_check(5'h08, 32'h3FF, "R1");
    read_check(5'h0C, 32'h0, "R1");
    // R10: second channel window is separate
    bus_write(5'h10, 32'h25);
    read_check(5'h10, 32'h25, "R10");
    read_check(5'h00, 32'h7F, "R10");

    run_case(0, 1, 4, 2, 1'b0, 1'b0, 23, "R3_R7_graceful");
    run_case(0, 2, 3, 1, 1'b0, 1'b1, 17, "R8_abrupt");
    run_case(0, 0, 5, 0, 1'b0, 1'b0, 12, "R4_zero_duty");
    run_case(0, 0, 3, 0, 1'b1, 1'b0, 8,  "R5_full_bit");
    run_case(0, 1, 2, 9, 1'b0, 1'b0, 9,  "R6_dc_over");
    run_case(0, 63, 1, 1, 1'b0, 1'b1, 200, "R3_max_prescale");
    run_case(0, 0, 0, 1, 1'b0, 1'b0, 5,  "R3_single_clock");
    run_case(1, 0, 7, 3, 1'b0, 1'b0, 20, "R10_ch1");
    run_case(0, 3, 2, 2, 1'b0, 1'b1, 1,  "R11_start");

    // R9: update mid-period takes effect at next boundary
    bus_write(5'h00, 32'h40);
    bus_write(5'h04, 32'd2);
    bus_write(5'h08, 32'd5);
    run_en[0] = 1'b1;
    for (int j = 0; j < 12; j++) push(0, wave(0, 5, 2, 1'b0, j), "R9_old");
    for (int j = 0; j < 8; j++)  push(0, wave(0, 2, 1, 1'b0, j), "R9_new");
    for (int j = 0; j < 6; j++)  push(0, 1'b0, "R9_stop");
    repeat (8) @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h08; bus_wdata = 32'd2;
    @(negedge clk);
    bus_addr = 5'h04; bus_wdata = 32'd1;
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (10) @(negedge clk);
    run_en[0] = 1'b0;
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule